// File: doc/BRIEF.md
# Circular Multi-Frame SRAM Recorder

This block records a stream of 16-bit pixels into a ring of whole-frame slots kept in two external asynchronous SRAM devices. Every slot holds exactly one frame. The block writes pixels one after another into a linear word space. The top bit of that space chooses which device is enabled, and the lower bits form the device address. When the last slot has been filled, writing wraps back to slot 0. Once the ring is full, every completed frame overwrites the oldest retained one, and the pointer to the oldest frame moves forward by one slot.

An external crash trigger ends recording. If a frame is in progress, the block finishes it first and then freezes. In the frozen state it shows how many complete frames it holds and accepts no more pixels. A readout request then replays every retained word, from the oldest frame to the newest. When the last word has been delivered, the ring is emptied and recording starts again. The block drives the address, data, chip-enable, write-enable, output-enable and byte-enable pins of the devices directly. Every access is a full 16-bit word.

The controller is a single state machine with these states:
- `ST_REC`: idle while recording. It accepts a pixel, or it freezes.
- `ST_WSETUP`: address and data are presented.
- `ST_WPULSE`: write-enable is held low.
- `ST_WHOLD`: write-enable is high again and the data is still driven. The pointers advance here.
- `ST_FROZEN`: the block waits for a readout request.
- `ST_RWAIT`: output-enable is low and the block counts the read wait.

The transitions are:
- `ST_REC` goes to `ST_FROZEN` when a trigger is pending and the frame offset is 0.
- `ST_REC` goes to `ST_WSETUP` when a pixel is offered.
- `ST_WSETUP` goes to `ST_WPULSE`.
- `ST_WPULSE` goes to `ST_WHOLD` after `WE_CYC` cycles.
- `ST_WHOLD` goes to `ST_REC`.
- `ST_FROZEN` goes to `ST_RWAIT` on `rd_start` when frames are held, or to `ST_REC` on `rd_start` when none are held.
- `ST_RWAIT` stays in `ST_RWAIT` after each captured word, and goes to `ST_REC` after the last word.

Top module: `bbr_frame_recorder`

## Requirements
- R1: After reset the following hold: `frozen` is 0, `frame_count` is 0, `pix_ready` is 1, both `sram_ce_n` bits are 1, and `sram_we_n` and `sram_oe_n` are 1.
- R2: A pixel write presents its address and data for one cycle and then holds `sram_we_n` low for exactly `WE_CYC` cycles. During the pulse `sram_oe_n` stays 1 and the data bus keeps the same value. The bus is tri-stated outside write cycles.
- R3: Linear word address bit `ADDR_W` selects the device: 0 selects `sram_ce_n[0]` and 1 selects `sram_ce_n[1]`. The low `ADDR_W` bits drive `sram_addr`. Exactly one chip enable is low during any access, and both are high while the block is idle in recording.
- R4: Pixels go to consecutive linear addresses. Slot k starts at k*`FRAME_WORDS`. After the last word of slot `NUM_SLOTS`-1, writing continues at linear address 0.
- R5: `frame_count` rises by one for each completed frame and stops at `NUM_SLOTS`. From then on, each completed frame moves the oldest-frame pointer forward by one slot.
- R6: A trigger that arrives during a frame lets that frame finish. The block then freezes: `frozen` becomes 1 and `pix_ready` becomes 0.
- R7: A trigger that arrives while idle at a frame boundary freezes the block on the next clock edge, and no partial frame is kept.
- R8: `rd_start` while frozen replays all `frame_count`*`FRAME_WORDS` words, oldest frame first and in write order. Each word comes with a one-cycle `rd_valid`.
- R9: During readout, `sram_oe_n` is low and a word is captured every `RD_WAIT` cycles.
- R10: After the last word is read out, or on `rd_start` with no frames held, the ring is cleared: `frame_count` is 0, `frozen` is 0 and recording resumes.
- R11: `rd_start` has no effect while recording. A trigger has no effect while frozen or reading.
- R12: `sram_bhe_n` and `sram_ble_n` are held low, so every access is a full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 16 | Pixel word |
| pix_ready | output | 1 | Pixel taken on this edge when valid |
| trigger | input | 1 | Crash trigger |
| rd_start | input | 1 | Begin readout while frozen |
| rd_valid | output | 1 | Readout word valid |
| rd_data | output | 16 | Readout word |
| frozen | output | 1 | Recording stopped, waiting for or doing readout |
| frame_count | output | CNT_W | Number of complete frames held |
| sram_addr | output | ADDR_W | Device word address |
| sram_dq | inout | 16 | Device data bus |
| sram_ce_n | output | 2 | Per-device chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_bhe_n | output | 1 | High byte enable, active low |
| sram_ble_n | output | 1 | Low byte enable, active low |

## Verification
The bench runs the recorder on a small configuration in which one slot crosses the boundary between the two devices. A design with a wrong device-select bit would then put words in the wrong device and return them corrupted. The ring is filled past capacity and frozen at a frame boundary. This exposes a wrap or oldest-pointer error as a readout that starts in the wrong slot or repeats a frame. A mid-frame trigger catches a design that freezes too early and keeps a partial frame. Triggers sent during readout and readout requests sent while recording catch designs that re-freeze or replay words they should not.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
    typedef enum logic [2:0] {
        ST_REC,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_FROZEN,
        ST_RWAIT
    } bbr_state_e;
endpackage

// File: rtl/bbr_wrap_ctr.sv
module bbr_wrap_ctr #(
    parameter int W     = 8,
    parameter int LIMIT = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         at_last
);
    assign at_last = (q == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (inc)
            q <= at_last ? '0 : q + 1'b1;
    end

    // R4: pointer never leaves its ring
    a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q <= W'(LIMIT - 1));
endmodule

// File: rtl/bbr_dev_sel.sv
module bbr_dev_sel #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W:0]   lin,
    input  logic              active,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ce_n
);
    assign addr = lin[ADDR_W-1:0];

    for (genvar g = 0; g < 2; g++) begin : g_dev
        assign ce_n[g] = ~(active && (lin[ADDR_W] == 1'(g)));
    end
endmodule

// File: rtl/bbr_frame_recorder.sv
module bbr_frame_recorder
    import bbr_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int FRAME_WORDS = 76800,
    parameter int NUM_SLOTS   = 27,
    parameter int WE_CYC      = 2,
    parameter int RD_WAIT     = 3,
    localparam int CNT_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [15:0]       pix_data,
    output logic              pix_ready,
    input  logic              trigger,
    input  logic              rd_start,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              frozen,
    output logic [CNT_W-1:0]  frame_count,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [15:0]       sram_dq,
    output logic [1:0]        sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              sram_bhe_n,
    output logic              sram_ble_n
);
    localparam int LIN_W = ADDR_W + 1;
    localparam int LW1   = LIN_W + 1;
    localparam int TOTAL = NUM_SLOTS * FRAME_WORDS;
    localparam int OFF_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
    localparam int WMAX  = (WE_CYC > RD_WAIT) ? WE_CYC : RD_WAIT;
    localparam int WC_W  = $clog2(WMAX + 1);

    bbr_state_e state, state_nxt;

    logic [WC_W-1:0]  wcnt;
    logic [15:0]      wdat;
    logic             trig_pend;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] rd_frames;
    logic [LIN_W-1:0] oldest_lin, oldest_nxt;
    logic [LW1-1:0]   old_sum;
    logic [LIN_W-1:0] wr_lin, rd_lin, acc_lin;
    logic [OFF_W-1:0] wr_off, rd_off;
    logic             wr_lin_last, wr_off_last, rd_lin_last, rd_off_last;
    logic             freeze_now, wr_step, frame_done, rd_begin, rd_step, rd_last, ring_clr;
    logic             dq_oe, acc_active;

    // ---------------- strobes ----------------
    always_comb begin
        freeze_now = (state == ST_REC) && (trig_pend || trigger) && (wr_off == '0);
        wr_step    = (state == ST_WHOLD);
        frame_done = wr_step && wr_off_last;
        rd_begin   = (state == ST_FROZEN) && rd_start;
        rd_step    = (state == ST_RWAIT) && (wcnt == WC_W'(RD_WAIT - 1));
        rd_last    = rd_off_last && (rd_frames == CNT_W'(1));
        ring_clr   = (rd_step && rd_last) || (rd_begin && (count == '0));
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_REC:    if (freeze_now) state_nxt = ST_FROZEN;
                       else if (pix_valid) state_nxt = ST_WSETUP;
            ST_WSETUP: state_nxt = ST_WPULSE;
            ST_WPULSE: if (wcnt == WC_W'(WE_CYC - 1)) state_nxt = ST_WHOLD;
            ST_WHOLD:  state_nxt = ST_REC;
            ST_FROZEN: if (rd_start) state_nxt = (count == '0) ? ST_REC : ST_RWAIT;
            ST_RWAIT:  if (rd_step && rd_last) state_nxt = ST_REC;
            default:   state_nxt = ST_REC;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_REC;
        else        state <= state_nxt;
    end

    // ---------------- outputs ----------------
    always_comb begin
        pix_ready  = (state == ST_REC) && !freeze_now;
        sram_we_n  = (state != ST_WPULSE);
        sram_oe_n  = (state != ST_RWAIT);
        dq_oe      = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);
        acc_active = dq_oe || (state == ST_RWAIT);
        acc_lin    = (state == ST_RWAIT) ? rd_lin : wr_lin;
        frozen     = (state == ST_FROZEN) || (state == ST_RWAIT);
    end

    assign sram_dq     = dq_oe ? wdat : 16'hzzzz;
    assign sram_bhe_n  = 1'b0;
    assign sram_ble_n  = 1'b0;
    assign frame_count = count;

    // ---------------- datapath registers ----------------
    assign old_sum    = {1'b0, oldest_lin} + LW1'(FRAME_WORDS);
    assign oldest_nxt = (old_sum >= LW1'(TOTAL)) ? LIN_W'(old_sum - LW1'(TOTAL))
                                                 : LIN_W'(old_sum);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt       <= '0;
            wdat       <= '0;
            trig_pend  <= 1'b0;
            count      <= '0;
            oldest_lin <= '0;
            rd_frames  <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            wcnt     <= ((state_nxt != state) || rd_step) ? '0 : wcnt + 1'b1;
            rd_valid <= rd_step;
            if (rd_step) rd_data <= sram_dq;
            if (pix_ready && pix_valid) wdat <= pix_data;

            if (freeze_now || ring_clr)
                trig_pend <= 1'b0;
            else if (trigger && !frozen)
                trig_pend <= 1'b1;

            if (ring_clr) begin
                count      <= '0;
                oldest_lin <= '0;
            end else if (frame_done) begin
                if (count == CNT_W'(NUM_SLOTS)) oldest_lin <= oldest_nxt;
                else                            count      <= count + 1'b1;
            end

            if (rd_begin)                    rd_frames <= count;
            else if (rd_step && rd_off_last) rd_frames <= rd_frames - 1'b1;
        end
    end

    // ---------------- pointers ----------------
    bbr_wrap_ctr #(.W(LIN_W), .LIMIT(TOTAL)) u_wr_lin (
        .clk(clk), .rst_n(rst_n), .clr(ring_clr), .load(1'b0), .load_val('0),
        .inc(wr_step), .q(wr_lin), .at_last(wr_lin_last));

    bbr_wrap_ctr #(.W(OFF_W), .LIMIT(FRAME_WORDS)) u_wr_off (
        .clk(clk), .rst_n(rst_n), .clr(ring_clr), .load(1'b0), .load_val('0),
        .inc(wr_step), .q(wr_off), .at_last(wr_off_last));

    bbr_wrap_ctr #(.W(LIN_W), .LIMIT(TOTAL)) u_rd_lin (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .load(rd_begin), .load_val(oldest_lin),
        .inc(rd_step), .q(rd_lin), .at_last(rd_lin_last));

    bbr_wrap_ctr #(.W(OFF_W), .LIMIT(FRAME_WORDS)) u_rd_off (
        .clk(clk), .rst_n(rst_n), .clr(rd_begin), .load(1'b0), .load_val('0),
        .inc(rd_step), .q(rd_off), .at_last(rd_off_last));

    bbr_dev_sel #(.ADDR_W(ADDR_W)) u_sel (
        .lin(acc_lin), .active(acc_active), .addr(sram_addr), .ce_n(sram_ce_n));

    // ---------------- assertions ----------------
    // R2: write pulse never overlaps output enable and always has data on the bus
    a_r2_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && dq_oe));
    // R2: write pulse lasts at least two cycles
    a_r2_we_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |=> !sram_we_n);
    // R2: address does not move while the pulse is low
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> $stable(sram_addr) && $stable(sram_ce_n));
    // R3: one device at most; exactly one during a strobe
    a_r3_one_device: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || !sram_oe_n) |-> ($countones(~sram_ce_n) == 1));
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sram_ce_n));
    // R5: frame count saturates
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(NUM_SLOTS));
    // R6: no pixel accepted while frozen
    a_r6_frozen_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !pix_ready);
    // R8: readout strobe is a single-cycle pulse
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/sim_bbr_frame_recorder.sv
`timescale 1ns/1ps
module sim_bbr_frame_recorder;
    localparam int AW  = 4;
    localparam int FW  = 6;
    localparam int NS  = 4;
    localparam int WEC = 2;
    localparam int RDW = 3;
    localparam int CW  = $clog2(NS + 1);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0;
    logic [15:0]   pix_data = '0;
    logic          pix_ready;
    logic          trigger = 1'b0;
    logic          rd_start = 1'b0;
    logic          rd_valid;
    logic [15:0]   rd_data;
    logic          frozen;
    logic [CW-1:0] frame_count;
    logic [AW-1:0] sram_addr;
    wire  [15:0]   sram_dq;
    logic [1:0]    sram_ce_n;
    logic          sram_we_n, sram_oe_n, sram_bhe_n, sram_ble_n;

    logic [15:0] mem0 [16];
    logic [15:0] mem1 [16];

    bbr_frame_recorder #(.ADDR_W(AW), .FRAME_WORDS(FW), .NUM_SLOTS(NS),
                         .WE_CYC(WEC), .RD_WAIT(RDW)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .trigger(trigger), .rd_start(rd_start),
        .rd_valid(rd_valid), .rd_data(rd_data), .frozen(frozen),
        .frame_count(frame_count), .sram_addr(sram_addr), .sram_dq(sram_dq),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_bhe_n(sram_bhe_n), .sram_ble_n(sram_ble_n));

    // SRAM device models
    always @(posedge clk) begin
        if (!sram_we_n) begin
            if (!sram_ce_n[0]) mem0[sram_addr] <= sram_dq;
            if (!sram_ce_n[1]) mem1[sram_addr] <= sram_dq;
        end
    end
    assign sram_dq = (!sram_oe_n && sram_we_n && sram_ce_n != 2'b11)
                   ? (!sram_ce_n[1] ? mem1[sram_addr] : mem0[sram_addr]) : 16'hzzzz;

    int n_chk = 0;
    int n_fail = 0;
    int n_rdv = 0;
    bit finished = 0;
    logic [15:0] exp_q [$];
    logic [15:0] hist [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard and checks bus timing
    int we_run = 0;
    logic [15:0] we_dq = '0;
    int since = 0;
    bit burst = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            since++;
            if (rd_valid) begin
                n_rdv++;
                if (burst) chk(since == RDW, "R9", "read word spacing", since, RDW);
                burst = 1;
                since = 0;
                if (exp_q.size() == 0)
                    chk(0, "R11", "read word with nothing pending", int'(rd_data), 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R8", "readout word", int'(rd_data), int'(e));
                end
            end else if (sram_oe_n) begin
                burst = 0;
            end

            if (!sram_we_n) begin
                we_run++;
                chk(sram_oe_n, "R2", "oe_n during write pulse", int'(sram_oe_n), 1);
                if (we_run > 1) chk(sram_dq == we_dq, "R2", "data held", int'(sram_dq), int'(we_dq));
                we_dq = sram_dq;
            end else if (we_run > 0) begin
                chk(we_run == WEC, "R2", "we_n low width", we_run, WEC);
                we_run = 0;
            end

            if (!sram_we_n || !sram_oe_n) begin
                chk($countones(~sram_ce_n) == 1, "R3", "one device enabled",
                    int'(sram_ce_n), 0);
                chk(!sram_bhe_n && !sram_ble_n, "R12", "byte enables low",
                    int'({sram_bhe_n, sram_ble_n}), 0);
            end else if (pix_ready) begin
                chk(sram_ce_n == 2'b11, "R3", "no device while idle", int'(sram_ce_n), 3);
            end
        end
    end

    // Driver tasks
    task automatic send(input logic [15:0] d);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = d;
        while (!pix_ready) @(negedge clk);
        @(negedge clk);
        pix_valid = 1'b0;
        hist.push_back(d);
    endtask

    task automatic pulse_trig();
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0;
    endtask

    task automatic wait_state(input bit want, input int lim);
        for (int i = 0; i < lim && frozen != want; i++) @(negedge clk);
    endtask

    task automatic load_expect(input int first);
        for (int i = first; i < hist.size(); i++) exp_q.push_back(hist[i]);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!frozen, "R1", "frozen after reset", int'(frozen), 0);
        chk(frame_count == 0, "R1", "frame_count after reset", int'(frame_count), 0);
        chk(pix_ready, "R1", "pix_ready after reset", int'(pix_ready), 1);
        chk(sram_ce_n == 2'b11 && sram_we_n && sram_oe_n, "R1", "strobes idle",
            int'({sram_ce_n, sram_we_n, sram_oe_n}), 15);
        chk(!sram_bhe_n && !sram_ble_n, "R12", "byte enables after reset",
            int'({sram_bhe_n, sram_ble_n}), 0);

        // Phase A: trigger in the middle of frame 2
        for (int i = 0; i < 14; i++) send(16'h1000 + 16'(i));
        pulse_trig();
        for (int i = 14; i < 18; i++) send(16'h1000 + 16'(i));
        wait_state(1'b1, 50);
        chk(frozen, "R6", "frozen after frame finished", int'(frozen), 1);
        chk(!pix_ready, "R6", "pix_ready while frozen", int'(pix_ready), 0);
        chk(frame_count == 3, "R6", "frame_count with finished frame", int'(frame_count), 3);
        chk(mem1[0] == hist[16], "R3", "linear word 16 in device 1", int'(mem1[0]), int'(hist[16]));
        chk(mem0[0] == hist[0], "R4", "slot 0 base", int'(mem0[0]), int'(hist[0]));
        chk(mem0[6] == hist[6], "R4", "slot 1 base", int'(mem0[6]), int'(hist[6]));
        load_expect(0);
        pulse_trig();                       // R11: ignored while frozen
        pulse_rd();
        wait_state(1'b0, 500);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "words still pending", exp_q.size(), 0);
        chk(n_rdv == 18, "R8", "words read", n_rdv, 18);
        chk(frame_count == 0, "R10", "ring cleared", int'(frame_count), 0);
        chk(!frozen && pix_ready, "R11", "trigger during frozen had no effect",
            int'({frozen, pix_ready}), 1);
        hist.delete();

        // Phase B: readout request while recording, then overfill the ring
        pulse_rd();
        repeat (20) @(negedge clk);
        chk(n_rdv == 18, "R11", "rd_start while recording", n_rdv, 18);
        chk(!frozen, "R11", "not frozen by rd_start", int'(frozen), 0);
        for (int i = 0; i < 18; i++) send(16'h2000 + 16'(i));
        repeat (6) @(negedge clk);
        chk(frame_count == 3, "R5", "count after three frames", int'(frame_count), 3);
        for (int i = 18; i < 30; i++) send(16'h2000 + 16'(i));
        repeat (6) @(negedge clk);
        chk(frame_count == 4, "R5", "count saturates", int'(frame_count), 4);
        for (int i = 30; i < 36; i++) send(16'h2000 + 16'(i));
        repeat (6) @(negedge clk);
        chk(!frozen, "R7", "still recording before trigger", int'(frozen), 0);
        pulse_trig();
        chk(frozen, "R7", "freeze at frame boundary", int'(frozen), 1);
        chk(frame_count == 4, "R7", "no partial frame counted", int'(frame_count), 4);
        chk(mem0[0] == hist[24], "R4", "wrap to slot 0", int'(mem0[0]), int'(hist[24]));
        chk(mem1[2] == hist[18], "R4", "slot 3 base in device 1", int'(mem1[2]), int'(hist[18]));
        load_expect(12);                    // R5: oldest is frame 2
        pulse_rd();
        wait_state(1'b0, 800);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "words still pending after wrap", exp_q.size(), 0);
        chk(n_rdv == 42, "R8", "words read after wrap", n_rdv, 42);
        chk(frame_count == 0, "R10", "ring cleared after wrap", int'(frame_count), 0);
        hist.delete();

        // Phase C: freeze with empty ring
        pulse_trig();
        chk(frozen, "R7", "freeze with empty ring", int'(frozen), 1);
        chk(frame_count == 0, "R7", "empty ring count", int'(frame_count), 0);
        pulse_rd();
        repeat (3) @(negedge clk);
        chk(!frozen && pix_ready, "R10", "resume with empty ring",
            int'({frozen, pix_ready}), 1);
        chk(n_rdv == 42, "R10", "no words from empty ring", n_rdv, 42);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule